// File: doc/BRIEF.md
# Handshake Byte Transfer Engine

This block moves bytes between a host processor and a small peripheral controller. It uses three active-low handshake lines and one 8-bit shift-data register. The host drives two of the lines through writes to a port register: an acknowledge line and an in-progress line. The engine drives the third line, a request line, back to the host. A byte moves on each change of the acknowledge/in-progress pair while in-progress is held low. A direction bit in an auxiliary control word picks the way the bytes travel. In the outbound direction, the host writes the shift register and the engine appends it to a 16-byte buffer. In the inbound direction, the engine loads the next byte of a prepared packet into the shift register for the host to read.

When in-progress is released, the engine closes the outbound packet and reports its byte count with a one-cycle pulse. While idle, the engine keeps the request line asserted as long as inbound bytes remain unread. It also offers a sync mode in which the request line follows the acknowledge line. Every transfer event, including a packet close or a new inbound load, schedules a shift-register interrupt. The interrupt rises after a programmable delay, or at once when the port direction register reads all ones.

Top module: `hs_xfer`

## Requirements
- R1: After synchronous reset, `treq_n` is 1, `sr_irq` is 0, `pkt_done` is 0 and `sr_data` is 0. The handshake history starts with both acknowledge and in-progress deasserted (high).
- R2: Outbound mode is selected when bit 4 of the control word is 1. In this mode, a `pb_wr` with bit 5 low whose bits {4,5} differ from the previous port write appends `sr_data` to the outbound buffer at the next free index. The buffer is readable at `out_raddr`.
- R3: The outbound buffer holds at most 16 bytes. Further bytes are dropped, and the stored count never exceeds 16.
- R4: When in-progress (bit 5) goes from 0 to 1 with at least one outbound byte stored, `pkt_done` pulses for one cycle with `pkt_len` equal to the count, and the count returns to zero. With zero bytes there is no pulse. An interrupt is scheduled in both cases.
- R5: Inbound mode is selected when control bit 4 is 0. In this mode, each qualifying handshake change loads the next unread inbound byte into `sr_data`, in push order.
- R6: Loading the last inbound byte drives `treq_n` to 1.
- R7: Two events drive `treq_n` to 0 while inbound bytes remain unread: a port write that leaves in-progress high (other than a sync toggle), and a packet commit while idle.
- R8: A port write with bit 5 high, following a write that also had bit 5 high, where bit 4 changes, is a sync toggle. It sets `treq_n` to the new bit 4 level and schedules an interrupt.
- R9: With `pb_dir` not equal to 8'hFF, `sr_irq` rises exactly DELAY_US microseconds of clock cycles after the clock edge that accepted the trigger. A new trigger restarts the count.
- R10: With `pb_dir` equal to 8'hFF, `sr_irq` rises at the same edge that accepts the trigger.
- R11: `sr_clr` clears `sr_irq`. A raise in the same cycle wins.
- R12: A port write with bit 5 low whose bits {4,5} equal the previous write moves no byte. A write in inbound mode with no unread bytes also moves no byte.
- R13: `in_commit` makes the pushed bytes the new inbound packet, restarts reading from its first byte and schedules an interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pb_wr | input | 1 | Host port write strobe |
| pb_wdata | input | 8 | Port value: bit 4 acknowledge, bit 5 in-progress (active low) |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 8 | Control word; bit 4 = 1 outbound, 0 inbound |
| pb_dir | input | 8 | Port direction register level; 8'hFF selects immediate interrupts |
| sr_wr | input | 1 | Host shift-register write strobe |
| sr_wdata | input | 8 | Shift-register write data |
| sr_clr | input | 1 | Clears the shift-register interrupt |
| in_push | input | 1 | Appends `in_byte` to the pending inbound packet |
| in_byte | input | 8 | Inbound byte |
| in_commit | input | 1 | Makes the pushed bytes the active inbound packet |
| out_raddr | input | 4 | Outbound buffer read index |
| treq_n | output | 1 | Transfer request to host, active low |
| sr_data | output | 8 | Shift-register contents |
| out_rdata | output | 8 | Outbound buffer byte at `out_raddr` |
| pkt_done | output | 1 | One-cycle outbound packet completion pulse |
| pkt_len | output | 5 | Byte count of the completed packet |
| sr_irq | output | 1 | Shift-register interrupt request |

## Verification
A stale handshake history shows up at the next port write. Either a byte is moved twice or skipped, visible on `sr_data` or in the outbound buffer, or a sync toggle drives the wrong `treq_n` level on the following cycle. A wrong read or write index changes the byte order or the `pkt_len` reported at the very next packet close. A wrong delay count shows only at the interrupt. It is exposed by sampling `sr_irq` one cycle before and at the exact expiry edge, including after a restart.

// File: rtl/hs_xfer_pkg.sv
package hs_xfer_pkg;
    // Port bit positions decoded from host writes (active low lines)
    localparam int PB_ACK_BIT = 4;
    localparam int PB_TIP_BIT = 5;
    // Direction bit in the control word: 1 = host to device
    localparam int CTL_OUT_BIT = 4;
    // Direction register value that bypasses the interrupt delay
    localparam logic [7:0] DIR_BYPASS = 8'hFF;
endpackage

// File: rtl/xfer_buf.sv
// xfer_buf: small byte store with one synchronous write port and one
// combinational read port. Assumes the caller keeps addresses in range.
module xfer_buf #(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    // Write one byte per enabled cycle
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Asynchronous read of the addressed byte
    assign rdata = mem[raddr];
endmodule

// File: rtl/sr_irq_delay.sv
// sr_irq_delay: turns a trigger pulse into a delayed interrupt level.
// A trigger restarts the countdown; bypass raises the interrupt at the
// trigger edge. Assumes DELAY_CYC >= 1.
module sr_irq_delay #(
    parameter int DELAY_CYC = 60000,
    localparam int CW = $clog2(DELAY_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic bypass,
    input  logic clr,
    output logic irq
);
    logic [CW-1:0] cnt;
    logic          armed;
    logic          expire;

    assign expire = armed && (cnt == CW'(1)) && !trig;

    // Countdown: restart on trigger, stop at expiry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            armed <= 1'b0;
        end else if (trig && !bypass) begin
            cnt   <= CW'(DELAY_CYC);
            armed <= 1'b1;
        end else if (trig) begin
            armed <= 1'b0;
        end else if (expire) begin
            armed <= 1'b0;
        end else if (armed) begin
            cnt <= cnt - CW'(1);
        end
    end

    // Interrupt level: raise wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n)                         irq <= 1'b0;
        else if ((trig && bypass) || expire) irq <= 1'b1;
        else if (clr)                        irq <= 1'b0;
    end
endmodule

// File: rtl/hs_engine.sv
// hs_engine: decodes host port writes into byte moves, end-of-packet and
// sync events; owns both buffers and their indices. Assumes pushes and
// commits are not issued during an inbound transfer.
module hs_engine
    import hs_xfer_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pb_wr,
    input  logic [7:0]    pb_wdata,
    input  logic          ctl_wr,
    input  logic [7:0]    ctl_wdata,
    input  logic          sr_wr,
    input  logic [7:0]    sr_wdata,
    input  logic          in_push,
    input  logic [7:0]    in_byte,
    input  logic          in_commit,
    input  logic [AW-1:0] out_raddr,
    output logic          treq_n,
    output logic [7:0]    sr_data,
    output logic [7:0]    out_rdata,
    output logic          pkt_done,
    output logic [PW-1:0] pkt_len,
    output logic          sched,
    output logic          ack_q,
    output logic          tip_q,
    output logic [PW-1:0] out_cnt
);
    logic          dir_out;
    logic [PW-1:0] in_size, rd_idx, wr_ptr;
    logic [7:0]    in_rdata;
    logic          new_ack, new_tip, pair_chg, xfer;
    logic          mv_out, mv_in, sync_tg, close, idle_wr;
    logic [PW-1:0] rd_nx;

    // Event decode from the current write and the stored handshake history
    always_comb begin
        new_ack  = pb_wdata[PB_ACK_BIT];
        new_tip  = pb_wdata[PB_TIP_BIT];
        pair_chg = (new_ack != ack_q) || (new_tip != tip_q);
        xfer     = pb_wr && !new_tip;
        mv_out   = xfer && dir_out && pair_chg && (out_cnt < PW'(DEPTH));
        mv_in    = xfer && !dir_out && pair_chg && (rd_idx < in_size);
        sync_tg  = pb_wr && new_tip && tip_q && (new_ack != ack_q);
        idle_wr  = pb_wr && new_tip && !sync_tg;
        close    = idle_wr && !tip_q;
        rd_nx    = rd_idx + PW'(1);
        sched    = mv_out || mv_in || sync_tg || close || in_commit;
    end

    xfer_buf #(.DEPTH(DEPTH)) u_out_buf (
        .clk(clk), .we(mv_out), .waddr(out_cnt[AW-1:0]), .wdata(sr_data),
        .raddr(out_raddr), .rdata(out_rdata)
    );

    xfer_buf #(.DEPTH(DEPTH)) u_in_buf (
        .clk(clk), .we(in_push && (wr_ptr < PW'(DEPTH))), .waddr(wr_ptr[AW-1:0]),
        .wdata(in_byte), .raddr(rd_idx[AW-1:0]), .rdata(in_rdata)
    );

    // Handshake history and direction select
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q   <= 1'b1;
            tip_q   <= 1'b1;
            dir_out <= 1'b0;
        end else begin
            if (pb_wr) begin
                ack_q <= new_ack;
                tip_q <= new_tip;
            end
            if (ctl_wr) dir_out <= ctl_wdata[CTL_OUT_BIT];
        end
    end

    // Shift register: host write or inbound byte load
    always_ff @(posedge clk) begin
        if (!rst_n)      sr_data <= '0;
        else if (mv_in)  sr_data <= in_rdata;
        else if (sr_wr)  sr_data <= sr_wdata;
    end

    // Outbound index and packet completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_cnt  <= '0;
            pkt_done <= 1'b0;
            pkt_len  <= '0;
        end else begin
            pkt_done <= 1'b0;
            if (mv_out) begin
                out_cnt <= out_cnt + PW'(1);
            end else if (close && (out_cnt != '0)) begin
                pkt_done <= 1'b1;
                pkt_len  <= out_cnt;
                out_cnt  <= '0;
            end
        end
    end

    // Inbound packet indices
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_size <= '0;
            rd_idx  <= '0;
            wr_ptr  <= '0;
        end else if (in_commit) begin
            in_size <= wr_ptr;
            rd_idx  <= '0;
            wr_ptr  <= '0;
        end else begin
            if (in_push && (wr_ptr < PW'(DEPTH))) wr_ptr <= wr_ptr + PW'(1);
            if (mv_in) rd_idx <= rd_nx;
        end
    end

    // Transfer request line toward the host
    always_ff @(posedge clk) begin
        if (!rst_n)                        treq_n <= 1'b1;
        else if (in_commit && tip_q)       treq_n <= (wr_ptr == '0);
        else if (mv_in && (rd_nx >= in_size)) treq_n <= 1'b1;
        else if (sync_tg)                  treq_n <= new_ack;
        else if (idle_wr && (rd_idx < in_size)) treq_n <= 1'b0;
    end
endmodule

// File: rtl/hs_xfer.sv
// hs_xfer: top of the handshake byte transfer engine. Joins the handshake
// decoder with the delayed shift-register interrupt. Assumes one host
// access per cycle.
module hs_xfer
    import hs_xfer_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter int CLK_HZ   = 200_000_000,
    parameter int DELAY_US = 300,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1,
    localparam int DELAY_CYC = (CLK_HZ / 1_000_000) * DELAY_US
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pb_wr,
    input  logic [7:0]    pb_wdata,
    input  logic          ctl_wr,
    input  logic [7:0]    ctl_wdata,
    input  logic [7:0]    pb_dir,
    input  logic          sr_wr,
    input  logic [7:0]    sr_wdata,
    input  logic          sr_clr,
    input  logic          in_push,
    input  logic [7:0]    in_byte,
    input  logic          in_commit,
    input  logic [AW-1:0] out_raddr,
    output logic          treq_n,
    output logic [7:0]    sr_data,
    output logic [7:0]    out_rdata,
    output logic          pkt_done,
    output logic [PW-1:0] pkt_len,
    output logic          sr_irq
);
    logic          sched;
    logic          ack_q, tip_q;
    logic [PW-1:0] out_cnt;

    hs_engine #(.DEPTH(DEPTH)) u_eng (
        .clk(clk), .rst_n(rst_n), .pb_wr(pb_wr), .pb_wdata(pb_wdata),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .sr_wr(sr_wr),
        .sr_wdata(sr_wdata), .in_push(in_push), .in_byte(in_byte),
        .in_commit(in_commit), .out_raddr(out_raddr), .treq_n(treq_n),
        .sr_data(sr_data), .out_rdata(out_rdata), .pkt_done(pkt_done),
        .pkt_len(pkt_len), .sched(sched), .ack_q(ack_q), .tip_q(tip_q),
        .out_cnt(out_cnt)
    );

    sr_irq_delay #(.DELAY_CYC(DELAY_CYC)) u_irq (
        .clk(clk), .rst_n(rst_n), .trig(sched),
        .bypass(pb_dir == DIR_BYPASS), .clr(sr_clr), .irq(sr_irq)
    );
endmodule

// File: rtl/hs_xfer_chk.sv
// hs_xfer_chk: protocol properties of the transfer engine, bound to hs_xfer.
module hs_xfer_chk #(
    parameter int DEPTH = 16,
    localparam int PW = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pb_wr,
    input logic [7:0]    pb_wdata,
    input logic          sr_wr,
    input logic [7:0]    sr_data,
    input logic          pkt_done,
    input logic [PW-1:0] pkt_len,
    input logic          sched,
    input logic [7:0]    pb_dir,
    input logic          sr_irq,
    input logic          ack_q,
    input logic          tip_q,
    input logic          treq_n,
    input logic [PW-1:0] out_cnt
);
    // R3
    out_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_cnt <= PW'(DEPTH));

    // R4
    pkt_len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |-> (pkt_len != '0) && (pkt_len <= PW'(DEPTH)));

    // R10
    irq_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sched && (pb_dir == 8'hFF)) |=> sr_irq);

    // R12
    no_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pb_wr && !pb_wdata[5] && !tip_q && (pb_wdata[4] == ack_q) && !sr_wr)
        |=> $stable(sr_data));

    // R8
    sync_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pb_wr && pb_wdata[5] && tip_q && (pb_wdata[4] != ack_q))
        |=> (treq_n == $past(pb_wdata[4])));
endmodule

bind hs_xfer hs_xfer_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .pb_wr(pb_wr), .pb_wdata(pb_wdata),
    .sr_wr(sr_wr), .sr_data(sr_data), .pkt_done(pkt_done), .pkt_len(pkt_len),
    .sched(sched), .pb_dir(pb_dir), .sr_irq(sr_irq), .ack_q(ack_q),
    .tip_q(tip_q), .treq_n(treq_n), .out_cnt(out_cnt)
);

// File: tb/hs_xfer_test.sv
`timescale 1ns/1ps
module hs_xfer_test;
    localparam int D = 200;  // 1 us at 200 MHz

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pb_wr = 0, ctl_wr = 0, sr_wr = 0, sr_clr = 0;
    logic       in_push = 0, in_commit = 0;
    logic [7:0] pb_wdata = 8'h30, ctl_wdata = 0, pb_dir = 0, sr_wdata = 0, in_byte = 0;
    logic [3:0] out_raddr = 0;
    logic       treq_n, pkt_done, sr_irq;
    logic [7:0] sr_data, out_rdata;
    logic [4:0] pkt_len;

    int checks = 0, errors = 0;
    int exp_len_q[$];

    always #2.5 clk = ~clk;

    hs_xfer #(.DEPTH(16), .CLK_HZ(200_000_000), .DELAY_US(1)) uut (
        .clk(clk), .rst_n(rst_n), .pb_wr(pb_wr), .pb_wdata(pb_wdata),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .pb_dir(pb_dir),
        .sr_wr(sr_wr), .sr_wdata(sr_wdata), .sr_clr(sr_clr),
        .in_push(in_push), .in_byte(in_byte), .in_commit(in_commit),
        .out_raddr(out_raddr), .treq_n(treq_n), .sr_data(sr_data),
        .out_rdata(out_rdata), .pkt_done(pkt_done), .pkt_len(pkt_len),
        .sr_irq(sr_irq)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        checks++;
        if (exp_len_q.size() != 0) begin
            errors++;
            $display("FAIL R4: actual=%0d expected=0 missing completions", exp_len_q.size());
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Monitor: pops expected packet lengths as completions appear
    always @(negedge clk) begin
        if (rst_n && pkt_done) begin
            checks++;
            if (exp_len_q.size() == 0) begin
                errors++;
                $display("FAIL R4: actual=%0d expected=no completion", pkt_len);
            end else begin
                int e;
                e = exp_len_q.pop_front();
                if (int'(pkt_len) != e) begin
                    errors++;
                    $display("FAIL R4: actual=%0d expected=%0d", pkt_len, e);
                end
            end
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic pb(input logic tip, input logic ack);
        @(negedge clk); pb_wr = 1; pb_wdata = {2'b00, tip, ack, 4'b0000};
        @(negedge clk); pb_wr = 0;
    endtask
    task automatic sr_put(input logic [7:0] b);
        @(negedge clk); sr_wr = 1; sr_wdata = b;
        @(negedge clk); sr_wr = 0;
    endtask
    task automatic ctl(input logic [7:0] v);
        @(negedge clk); ctl_wr = 1; ctl_wdata = v;
        @(negedge clk); ctl_wr = 0;
    endtask
    task automatic clr();
        @(negedge clk); sr_clr = 1;
        @(negedge clk); sr_clr = 0;
    endtask
    task automatic push(input logic [7:0] b);
        @(negedge clk); in_push = 1; in_byte = b;
        @(negedge clk); in_push = 0;
    endtask
    task automatic commit();
        @(negedge clk); in_commit = 1;
        @(negedge clk); in_commit = 0;
    endtask
    // Driver: expects a completion of n bytes
    task automatic expect_pkt(input int n);
        exp_len_q.push_back(n);
    endtask

    initial begin
        #(5 * 150000);
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        wait_n(4);
        rst_n = 1;
        wait_n(1);
        // R1 reset state
        check("R1 treq_n", treq_n, 1);
        check("R1 sr_irq", sr_irq, 0);
        check("R1 pkt_done", pkt_done, 0);
        check("R1 sr_data", sr_data, 0);

        // R10 / R8 / R11 with bypass direction
        pb_dir = 8'hFF;
        pb(1, 0);
        check("R10 immediate irq", sr_irq, 1);
        check("R8 treq follows ack low", treq_n, 0);
        clr();
        check("R11 clear", sr_irq, 0);
        pb(1, 1);
        check("R8 treq follows ack high", treq_n, 1);
        clr();

        // R9 delayed interrupt and restart
        pb_dir = 8'h00;
        pb(1, 0);
        wait_n(D - 1);
        check("R9 before expiry", sr_irq, 0);
        wait_n(1);
        check("R9 at expiry", sr_irq, 1);
        clr();
        pb(1, 1);
        wait_n(100);
        pb(1, 0);
        wait_n(D - 1);
        check("R9 restart before expiry", sr_irq, 0);
        wait_n(1);
        check("R9 restart at expiry", sr_irq, 1);
        pb(1, 1);
        wait_n(D + 2);
        clr();

        // R2 / R12 / R4 outbound packet of three bytes
        ctl(8'h10);
        sr_put(8'hA1); pb(0, 1);
        sr_put(8'hB2); pb(0, 0);
        sr_put(8'hC3); pb(0, 1);
        sr_put(8'hD4); pb(0, 1);   // R12 unchanged pair, no move
        expect_pkt(3);
        pb(1, 1);
        out_raddr = 4'd0; wait_n(1); check("R2 byte0", out_rdata, 8'hA1);
        out_raddr = 4'd1; wait_n(1); check("R2 byte1", out_rdata, 8'hB2);
        out_raddr = 4'd2; wait_n(1); check("R2 byte2", out_rdata, 8'hC3);
        wait_n(D);
        check("R4 irq after close", sr_irq, 1);
        clr();

        // R3 overflow: 18 bytes offered, 16 kept
        for (int i = 0; i < 18; i++) begin
            sr_put(8'h40 + 8'(i));
            pb(0, 1'(i));
        end
        expect_pkt(16);
        pb(1, 1);
        out_raddr = 4'd15; wait_n(1); check("R3 last kept byte", out_rdata, 8'h4F);
        out_raddr = 4'd0;  wait_n(1); check("R3 first byte", out_rdata, 8'h40);
        wait_n(D + 2);
        clr();

        // R4 empty packet: no completion, still an interrupt
        ctl(8'h00);
        pb(0, 1);
        pb(1, 1);
        wait_n(D);
        check("R4 empty close irq", sr_irq, 1);
        clr();

        // R5 / R6 / R7 / R13 inbound packet
        push(8'h11); push(8'h22); push(8'h33);
        commit();
        check("R7 treq on commit", treq_n, 0);
        pb(0, 1);
        check("R5 byte0", sr_data, 8'h11);
        check("R7 treq held", treq_n, 0);
        pb(0, 0);
        check("R5 byte1", sr_data, 8'h22);
        pb(0, 1);
        check("R5 byte2", sr_data, 8'h33);
        check("R6 treq released", treq_n, 1);
        pb(0, 0);
        check("R12 no unread byte", sr_data, 8'h33);
        pb(1, 1);
        check("R6 treq stays high", treq_n, 1);
        wait_n(D + 2);
        clr();

        push(8'h5A); push(8'h6B);
        commit();
        check("R13 treq on reload", treq_n, 0);
        pb(0, 1);
        check("R13 reads from first byte", sr_data, 8'h5A);
        pb(1, 1);
        check("R7 treq with byte left", treq_n, 0);
        wait_n(D);
        check("R13 irq scheduled", sr_irq, 1);
        clr();
        wait_n(2);
        finish_run();
    end
endmodule